// File: doc/BRIEF.md
# Speculative Load Ordering Guard

This block lets a load run ahead of older stores whose addresses are not yet known, and detects when that guess turns out wrong. Every load and store is entered into a small circular ordering buffer when it is dispatched. A load asking to issue receives an immediate go or wait answer. The answer is go when no older store is still unresolved. It is also go when a small learned table, indexed by the load's PC bits, predicts that the load does not collide with older stores. A load that is refused waits until every older store has an address, and is then allowed without asking the table.

When a store's address arrives, the block compares it against every younger load that has already executed. If any of them read the same word, the oldest such load is named for replay. Its table entry is forced to the never-bypass value, and a penalty window opens during which no load is allowed to issue. Each load that retires after executing lowers its table entry by one, so a load that stops colliding eventually regains permission to bypass. Only addresses, ages and decisions are modelled. Data values, caches and commit are outside the block.

Top module: `spec_ld_guard`

## Requirements
- R1: After reset the buffer is empty and `alloc_ready` is 1. Each accepted allocation gets `alloc_tag` equal to the current slot index, which starts at 0 and advances by one modulo 8. With 8 entries held, `alloc_ready` is 0 and an allocation request is ignored, leaving `alloc_tag` unchanged.
- R2: A load request whose buffer entry is a valid, not-yet-executed load, and which has no older unresolved store, gets `ld_grant`=1 in the same cycle, unless the penalty window is open.
- R3: Each PC index (4 bits) selects a 2-bit counter, reset to 0. A load with an older unresolved store is granted only if its counter is 0 or 1. A counter value of 2 or 3 refuses it.
- R4: A refused load is granted in the first cycle after the last older store's address has been resolved, whatever its counter holds.
- R5: When a store resolves to address A, any younger load that has executed to A, including one completing in that same cycle, raises `replay_valid` for one cycle on the following cycle, with `replay_tag` naming it.
- R6: When several younger executed loads match the resolved address, `replay_tag` names the oldest of them.
- R7: Loads older than the resolving store, and younger loads executed to a different address, cause no replay.
- R8: A replayed load's counter becomes 3 and its executed state is cleared, so it may be granted again once the penalty window closes.
- R9: `replay_busy` rises together with `replay_valid` and stays high for exactly 20 cycles. No load is granted while it is high.
- R10: Retiring a load that has executed lowers its counter by one, saturating at 0.
- R11: `retire_valid` frees the oldest entry, which makes room for one more allocation in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Enter a new memory op at the young end |
| alloc_is_load | input | 1 | 1 = load, 0 = store |
| alloc_pc | input | PCW | PC index of the new op |
| alloc_ready | output | 1 | Buffer has room |
| alloc_tag | output | TW | Tag the next accepted op receives |
| st_res_valid | input | 1 | Store address resolved |
| st_res_tag | input | TW | Tag of the resolving store |
| st_res_addr | input | AW | Word address of that store |
| ld_req_valid | input | 1 | Load asks to issue |
| ld_req_tag | input | TW | Tag of the asking load |
| ld_grant | output | 1 | Go (1) or wait (0) for the asking load |
| ld_done_valid | input | 1 | Load finished executing |
| ld_done_tag | input | TW | Tag of the finished load |
| ld_done_addr | input | AW | Word address the load read |
| retire_valid | input | 1 | Free the oldest entry |
| replay_valid | output | 1 | One-cycle replay notice |
| replay_tag | output | TW | Load to re-execute |
| replay_busy | output | 1 | Penalty window open |

## Verification
`ld_grant`, `alloc_ready` and `alloc_tag` are combinational in the current request and the registered state, so they are due in the same cycle as the request. Any state change, such as a resolved store or a retrained counter, shows up in answers from the next cycle on. `replay_valid` and `replay_tag` follow the resolving edge by one cycle, and `replay_busy` covers that cycle and the 19 after it. The bench drives inputs on the falling edge, compares every output against its behavioural model 1 ns later, and advances the model on the rising edge, so each result is checked in the cycle it is due.

// File: rtl/spec_ld_guard.sv
module spec_ld_guard #(
  parameter int DEPTH   = 8,
  parameter int AW      = 32,
  parameter int PCW     = 4,
  parameter int PENALTY = 20,
  parameter int TW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          alloc_is_load,
  input  logic [PCW-1:0] alloc_pc,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic          st_res_valid,
  input  logic [TW-1:0] st_res_tag,
  input  logic [AW-1:0] st_res_addr,
  input  logic          ld_req_valid,
  input  logic [TW-1:0] ld_req_tag,
  output logic          ld_grant,
  input  logic          ld_done_valid,
  input  logic [TW-1:0] ld_done_tag,
  input  logic [AW-1:0] ld_done_addr,
  input  logic          retire_valid,
  output logic          replay_valid,
  output logic [TW-1:0] replay_tag,
  output logic          replay_busy
);
  localparam int NPRED = 1 << PCW;
  localparam int CW    = $clog2(PENALTY + 1);

  logic [DEPTH-1:0] e_v, e_ld, e_av, e_ex;
  logic [AW-1:0]    e_addr [DEPTH];
  logic [PCW-1:0]   e_pc   [DEPTH];
  logic [1:0]       ctr    [NPRED];
  logic [TW-1:0]    head, tail;
  logic [TW:0]      cnt;
  logic [CW-1:0]    bcnt;

  logic [TW-1:0]    rel [DEPTH];
  logic             older_unres, req_ok;
  logic             st_ok, hit;
  logic [TW-1:0]    vt, best;
  logic             do_alloc, ret;

  assign alloc_ready = cnt != (TW+1)'(DEPTH);
  assign alloc_tag   = tail;
  assign do_alloc    = alloc_valid && alloc_ready;
  assign ret         = retire_valid && cnt != '0;
  assign replay_busy = bcnt != '0;

  always_comb
    for (int i = 0; i < DEPTH; i++) rel[i] = TW'(i) - head;

  assign req_ok = e_v[ld_req_tag] && e_ld[ld_req_tag] && !e_ex[ld_req_tag];
  assign st_ok  = e_v[st_res_tag] && !e_ld[st_res_tag];

  always_comb begin
    older_unres = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (e_v[i] && !e_ld[i] && !e_av[i] && rel[i] < rel[ld_req_tag])
        older_unres = 1'b1;
  end

  assign ld_grant = ld_req_valid && req_ok && !replay_busy &&
                    (!older_unres || ctr[e_pc[ld_req_tag]] < 2'd2);

  always_comb begin
    logic          ex_i;
    logic [AW-1:0] a_i;
    hit  = 1'b0;
    vt   = '0;
    best = '1;
    for (int i = 0; i < DEPTH; i++) begin
      ex_i = e_ex[i] || (ld_done_valid && ld_done_tag == TW'(i));
      a_i  = (ld_done_valid && ld_done_tag == TW'(i)) ? ld_done_addr : e_addr[i];
      if (st_res_valid && st_ok && e_v[i] && e_ld[i] && ex_i && a_i == st_res_addr &&
          rel[i] > rel[st_res_tag] && (!hit || rel[i] < best)) begin
        hit  = 1'b1;
        vt   = TW'(i);
        best = rel[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v  <= '0;
      e_ld <= '0;
      e_av <= '0;
      e_ex <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= '0;
        e_pc[i]   <= '0;
      end
      for (int p = 0; p < NPRED; p++) ctr[p] <= 2'd0;
      head         <= '0;
      tail         <= '0;
      cnt          <= '0;
      bcnt         <= '0;
      replay_valid <= 1'b0;
      replay_tag   <= '0;
    end else begin
      if (do_alloc) begin
        e_v[tail]  <= 1'b1;
        e_ld[tail] <= alloc_is_load;
        e_av[tail] <= 1'b0;
        e_ex[tail] <= 1'b0;
        e_pc[tail] <= alloc_pc;
        tail       <= tail + 1'b1;
      end
      if (st_res_valid && st_ok) begin
        e_av[st_res_tag]   <= 1'b1;
        e_addr[st_res_tag] <= st_res_addr;
      end
      if (ld_done_valid && e_v[ld_done_tag] && e_ld[ld_done_tag]) begin
        e_ex[ld_done_tag]   <= 1'b1;
        e_addr[ld_done_tag] <= ld_done_addr;
      end
      if (ret) begin
        e_v[head] <= 1'b0;
        head      <= head + 1'b1;
        if (e_ld[head] && e_ex[head] && ctr[e_pc[head]] != 2'd0)
          ctr[e_pc[head]] <= ctr[e_pc[head]] - 2'd1;
      end
      cnt <= cnt + (TW+1)'(do_alloc) - (TW+1)'(ret);
      if (hit) begin
        e_ex[vt]      <= 1'b0;
        ctr[e_pc[vt]] <= 2'd3;
        bcnt          <= CW'(PENALTY);
        replay_valid  <= 1'b1;
        replay_tag    <= vt;
      end else begin
        replay_valid <= 1'b0;
        if (bcnt != '0) bcnt <= bcnt - 1'b1;
      end
    end
  end

  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> $stable(alloc_tag));
  p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(st_res_valid));
  p_busy_with_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> replay_busy);
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replay_busy) |-> replay_valid);
  p_no_grant_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    replay_busy |-> !ld_grant);
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (TW+1)'(DEPTH));
endmodule

// File: tb/sim_spec_ld_guard.sv
`timescale 1ns/1ps
module sim_spec_ld_guard;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic alloc_valid = 0, alloc_is_load = 0;
  logic [3:0] alloc_pc = 0;
  logic alloc_ready;
  logic [2:0] alloc_tag;
  logic st_res_valid = 0;
  logic [2:0] st_res_tag = 0;
  logic [31:0] st_res_addr = 0;
  logic ld_req_valid = 0;
  logic [2:0] ld_req_tag = 0;
  logic ld_grant;
  logic ld_done_valid = 0;
  logic [2:0] ld_done_tag = 0;
  logic [31:0] ld_done_addr = 0;
  logic retire_valid = 0;
  logic replay_valid, replay_busy;
  logic [2:0] replay_tag;

  spec_ld_guard u0 (.*);

  typedef struct { bit ld; int tag; bit av; bit ex; int addr; int pc; } ent_t;
  ent_t q[$];
  int pred[16];
  int busy = 0, mrt = 0, ntag = 0;
  bit mrv = 0;
  int errors = 0, checks = 0;
  bit o_grant, o_rv, o_busy, o_ready;
  int o_rt, o_tag;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", r, $time, act, exp);
    end
  endtask

  function automatic int find(int tag);
    foreach (q[i]) if (q[i].tag == tag) return i;
    return -1;
  endfunction

  function automatic bit exp_grant();
    int p;
    bit ou;
    p = find(int'(ld_req_tag));
    if (!ld_req_valid || p < 0 || busy != 0) return 0;
    if (!q[p].ld || q[p].ex) return 0;
    ou = 0;
    for (int i = 0; i < p; i++) if (!q[i].ld && !q[i].av) ou = 1;
    return !ou || pred[q[p].pc] < 2;
  endfunction

  task automatic model_step();
    bit hit = 0, rdy;
    int vt = 0, vpc = 0, ps, pd;
    rdy = q.size() < 8;
    ps = find(int'(st_res_tag));
    if (st_res_valid && ps >= 0 && !q[ps].ld)
      for (int i = ps + 1; i < q.size(); i++) begin
        bit now = ld_done_valid && int'(ld_done_tag) == q[i].tag;
        int a = now ? int'(ld_done_addr) : q[i].addr;
        if (q[i].ld && (q[i].ex || now) && a == int'(st_res_addr)) begin
          hit = 1; vt = q[i].tag; vpc = q[i].pc; break;
        end
      end
    if (st_res_valid && ps >= 0) begin q[ps].av = 1; q[ps].addr = int'(st_res_addr); end
    pd = find(int'(ld_done_tag));
    if (ld_done_valid && pd >= 0) begin q[pd].ex = 1; q[pd].addr = int'(ld_done_addr); end
    if (retire_valid && q.size() > 0) begin
      ent_t f = q.pop_front();
      if (f.ld && f.ex && pred[f.pc] > 0) pred[f.pc]--;
    end
    if (hit) begin
      int p = find(vt);
      if (p >= 0) q[p].ex = 0;
      pred[vpc] = 3; busy = 20; mrv = 1; mrt = vt;
    end else begin
      mrv = 0;
      if (busy > 0) busy--;
    end
    if (alloc_valid && rdy) begin
      ent_t e;
      e.ld = alloc_is_load; e.tag = ntag; e.av = 0; e.ex = 0; e.addr = 0; e.pc = int'(alloc_pc);
      q.push_back(e);
      ntag = (ntag + 1) % 8;
    end
  endtask

  task automatic cyc();
    #1;
    o_grant = ld_grant; o_rv = replay_valid; o_rt = int'(replay_tag);
    o_busy = replay_busy; o_ready = alloc_ready; o_tag = int'(alloc_tag);
    chk("R1/R11 alloc_ready", int'(alloc_ready), int'(q.size() < 8));
    chk("R1 alloc_tag", int'(alloc_tag), ntag);
    chk("R2/R3/R4/R9 ld_grant", int'(ld_grant), int'(exp_grant()));
    chk("R5/R7 replay_valid", int'(replay_valid), int'(mrv));
    if (mrv) chk("R5/R6 replay_tag", int'(replay_tag), mrt);
    chk("R9 replay_busy", int'(replay_busy), int'(busy != 0));
    @(posedge clk);
    model_step();
    @(negedge clk);
    alloc_valid = 0; st_res_valid = 0; ld_req_valid = 0; ld_done_valid = 0; retire_valid = 0;
  endtask

  task automatic alloc(bit ld, int pc, output int tag);
    alloc_valid = 1; alloc_is_load = ld; alloc_pc = 4'(pc);
    cyc();
    tag = o_tag;
  endtask
  task automatic req(int t); ld_req_valid = 1; ld_req_tag = 3'(t); cyc(); endtask
  task automatic done(int t, int a); ld_done_valid = 1; ld_done_tag = 3'(t); ld_done_addr = 32'(a); cyc(); endtask
  task automatic resolve(int t, int a); st_res_valid = 1; st_res_tag = 3'(t); st_res_addr = 32'(a); cyc(); endtask
  task automatic retire(int n); for (int i = 0; i < n; i++) begin retire_valid = 1; cyc(); end endtask
  task automatic drain_busy();
    for (int i = 0; i < 40 && (busy != 0 || mrv); i++) cyc();
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t, k;
    foreach (pred[i]) pred[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cyc();
    chk("R1 reset ready", int'(o_ready), 1);
    chk("R1 reset tag", o_tag, 0);

    alloc(1, 2, t); chk("R1 first tag", t, 0);
    req(0); chk("R2 grant with no older store", int'(o_grant), 1);
    done(0, 'h10); retire(1);

    alloc(0, 0, t); alloc(1, 5, t);
    req(2); chk("R3 bypass at counter 0", int'(o_grant), 1);
    done(2, 'h100);
    resolve(1, 'h100);
    k = 0;
    for (int i = 0; i < 30; i++) begin
      ld_req_valid = 1; ld_req_tag = 3'd2;
      cyc();
      if (i == 0) begin
        chk("R5 replay raised", int'(o_rv), 1);
        chk("R5 replay tag", o_rt, 2);
      end
      if (!o_busy) break;
      k++;
      chk("R9 no grant while busy", int'(o_grant), 0);
    end
    chk("R9 busy length", k, 20);
    chk("R8 replayed load granted again", int'(o_grant), 1);
    done(2, 'h100); retire(2);

    alloc(0, 0, t); alloc(1, 5, t);
    req(4); chk("R3 refused at counter 2", int'(o_grant), 0);
    resolve(3, 'h200);
    req(4); chk("R4 granted after older stores resolve", int'(o_grant), 1);
    done(4, 'h300); retire(2);

    alloc(0, 0, t); alloc(1, 5, t);
    req(6); chk("R10 counter lowered to 1 allows bypass", int'(o_grant), 1);
    done(6, 'h400);
    resolve(5, 'h500);
    cyc(); chk("R7 different address no replay", int'(o_rv), 0);
    retire(2);

    alloc(0, 0, t); chk("R1 tag 7", t, 7);
    alloc(1, 0, t); chk("R1 tag wraps to 0", t, 0);
    alloc(1, 1, t);
    req(0); req(1);
    done(0, 'h40); done(1, 'h40);
    resolve(7, 'h40);
    cyc(); chk("R6 oldest match reported", o_rt, 0);
    chk("R6 replay raised", int'(o_rv), 1);
    drain_busy(); retire(3);

    alloc(1, 3, t); alloc(0, 0, t); alloc(1, 4, t);
    req(2); done(2, 'h80);
    req(4); done(4, 'h90);
    resolve(3, 'h80);
    cyc(); chk("R7 older load no replay", int'(o_rv), 0);
    retire(3);

    for (int i = 0; i < 8; i++) alloc(0, 0, t);
    cyc(); chk("R1 full not ready", int'(o_ready), 0);
    alloc(0, 0, t);
    cyc(); chk("R1 ignored alloc keeps tag", o_tag, 5);
    retire(1);
    cyc(); chk("R11 ready after retire", int'(o_ready), 1);
    alloc(0, 0, t); chk("R11 freed slot reused", t, 5);
    retire(8);

    alloc(0, 0, t); alloc(1, 6, t);
    req(7); chk("R2 grant before conflict", int'(o_grant), 1);
    st_res_valid = 1; st_res_tag = 3'd6; st_res_addr = 'h700;
    ld_done_valid = 1; ld_done_tag = 3'd7; ld_done_addr = 'h700;
    cyc();
    cyc(); chk("R5 same-cycle completion replayed", o_rt, 7);
    chk("R5 same-cycle replay raised", int'(o_rv), 1);
    drain_busy(); retire(2);
    cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule